// File: doc/BRIEF.md
# Watchdog Timing Strap Detector

After every reset event, while the supply is above its threshold, this block works out how the watchdog timing-select pin is strapped and turns the result into the two window bounds that the window watchdog uses. There are three possible straps. The pin can be pulled up to the supply, left floating, or tied to a capacitor to ground. The block sees the pin only as digital samples. It drives an enable for an external constant-current source, and it reads back a flag from an external comparator that rises once the pin has charged to its threshold.

The detection sequence runs in a fixed order:

1. With charging off, the block waits a settle period and then samples the pin. A high pin means the pin is pulled up.
2. Otherwise the block enables charging and counts cycles.
3. A threshold crossing inside the probe window means a capacitor is fitted. The measured charge time is then scaled linearly into an upper bound, and the lower bound is half of it.
4. No crossing inside the window means the pin is floating.

Both fixed modes use bounds set by parameters. All bounds are expressed in watchdog ticks: 1600000/800000 when floating and 11000/1850 when pulled up.

The done flag stays low until the bounds are valid. It is intended to hold the downstream watchdog in reset until then.

Top module: `wd_strap_probe`

## Requirements
- R1: During and straight after reset, `done` and `chg_en` are 0, `mode` is 0 (none) and both bounds are 0.
- R2: A `start` pulse begins a settle phase of SETTLE_CYC cycles with `chg_en` low. If `pin_hi` is 1 at its end, `done` rises SETTLE_CYC cycles after the start edge with `mode`=2 (pulled up), `hi_bound`=PULL_HI and `lo_bound`=PULL_LO, and `chg_en` never rises.
- R3: If `pin_hi` is 0 at the end of settle, `chg_en` rises right away and stays high until a comparator hit or for at most PROBE_CYC cycles.
- R4: If `cmp_hit` is seen in the charge cycle with index N (counting from 0, N < PROBE_CYC), then `mode`=3 (capacitor), `hi_bound`=((N*CAP_SCALE)>>CAP_FRAC)+CAP_OFFSET, and `done` rises SETTLE_CYC+1+N cycles after the start edge.
- R5: In capacitor mode `lo_bound` equals `hi_bound` shifted right by one.
- R6: If no hit occurs within PROBE_CYC charge cycles, `mode`=1 (floating), `hi_bound`=FLOAT_HI and `lo_bound`=FLOAT_LO, and `done` rises SETTLE_CYC+PROBE_CYC cycles after the start edge.
- R7: Once `done` is high, `mode` and both bounds hold until the next `start`. The cycle after a `start`, `done` is 0 and `mode` is 0.
- R8: `chg_en` and `done` are never high together. `cmp_hit` while idle or done, and `pin_hi` during charging, have no effect on the outputs.
- R9: A `start` during a running probe abandons it and restarts from the settle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to (re)run detection |
| pin_hi | input | 1 | Digital sample of the timing-select pin |
| cmp_hit | input | 1 | Comparator flag: pin has reached its charge threshold |
| chg_en | output | 1 | Enables the external charge current |
| mode | output | 2 | 0 none, 1 floating, 2 pulled up, 3 capacitor |
| lo_bound | output | BOUND_W | Lower window bound in watchdog ticks |
| hi_bound | output | BOUND_W | Upper window bound in watchdog ticks |
| done | output | 1 | Bounds valid; low holds the watchdog in reset |

## Verification
The assertions check on every cycle that charging and done are mutually exclusive, that results hold until a restart, that a restart clears the result, that the capacitor lower bound is half the upper, that the fixed-mode bounds match their mode, and that a charge run never exceeds the probe window. Only the bench's scenarios can show the exact completion cycle of each mode, the charge-time-to-bound arithmetic at zero, mid-range and last-cycle hits, and the edge between a last-cycle hit and a timeout. The bench also shows that stray inputs are ignored and that a restart in mid-probe is clean.

// File: rtl/wd_strap_probe.sv
module wd_strap_probe #(
  parameter int          SETTLE_CYC = 4,
  parameter int          PROBE_CYC  = 64,
  parameter int          BOUND_W    = 32,
  parameter int unsigned FLOAT_LO   = 800000,
  parameter int unsigned FLOAT_HI   = 1600000,
  parameter int unsigned PULL_LO    = 1850,
  parameter int unsigned PULL_HI    = 11000,
  parameter int unsigned CAP_SCALE  = 1234,
  parameter int unsigned CAP_FRAC   = 4,
  parameter int unsigned CAP_OFFSET = 55000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pin_hi,
  input  logic               cmp_hit,
  output logic               chg_en,
  output logic [1:0]         mode,
  output logic [BOUND_W-1:0] lo_bound,
  output logic [BOUND_W-1:0] hi_bound,
  output logic               done
);
  localparam int CNT_W  = $clog2((PROBE_CYC > SETTLE_CYC) ? PROBE_CYC : SETTLE_CYC) + 1;
  localparam int PROD_W = CNT_W + BOUND_W;
  localparam logic [1:0] M_NONE = 2'd0, M_FLOAT = 2'd1, M_PULL = 2'd2, M_CAP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CHARGE, S_DONE} st_t;
  st_t state;
  logic [CNT_W-1:0] cnt;

  logic [PROD_W-1:0]  prod;
  logic [BOUND_W-1:0] cap_hi;
  assign prod   = PROD_W'(cnt) * PROD_W'(CAP_SCALE);
  assign cap_hi = BOUND_W'(prod >> CAP_FRAC) + BOUND_W'(CAP_OFFSET);

  assign chg_en = (state == S_CHARGE);
  assign done   = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      mode     <= M_NONE;
      lo_bound <= '0;
      hi_bound <= '0;
    end else if (start) begin
      state    <= S_SETTLE;
      cnt      <= '0;
      mode     <= M_NONE;
      lo_bound <= '0;
      hi_bound <= '0;
    end else begin
      case (state)
        S_SETTLE:
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            if (pin_hi) begin
              state    <= S_DONE;
              mode     <= M_PULL;
              lo_bound <= BOUND_W'(PULL_LO);
              hi_bound <= BOUND_W'(PULL_HI);
            end else begin
              state <= S_CHARGE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_CHARGE:
          if (cmp_hit) begin
            state    <= S_DONE;
            mode     <= M_CAP;
            hi_bound <= cap_hi;
            lo_bound <= cap_hi >> 1;
          end else if (cnt == CNT_W'(PROBE_CYC - 1)) begin
            state    <= S_DONE;
            mode     <= M_FLOAT;
            lo_bound <= BOUND_W'(FLOAT_LO);
            hi_bound <= BOUND_W'(FLOAT_HI);
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wd_strap_probe_chk.sv
module wd_strap_probe_chk #(
  parameter int          PROBE_CYC = 64,
  parameter int          BOUND_W   = 32,
  parameter int unsigned FLOAT_LO  = 800000,
  parameter int unsigned FLOAT_HI  = 1600000,
  parameter int unsigned PULL_LO   = 1850,
  parameter int unsigned PULL_HI   = 11000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               chg_en,
  input logic [1:0]         mode,
  input logic [BOUND_W-1:0] lo_bound,
  input logic [BOUND_W-1:0] hi_bound,
  input logic               done
);
  localparam int RUN_W = $clog2(PROBE_CYC + 1) + 1;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (chg_en) run <= run + 1'b1;
    else run <= '0;
  end

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(chg_en && done));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(mode) && $stable(lo_bound) && $stable(hi_bound)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && mode == 2'd0));

  // R5
  half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == 2'd3) |-> (lo_bound == (hi_bound >> 1)));

  // R6
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == 2'd1) |-> (hi_bound == BOUND_W'(FLOAT_HI) && lo_bound == BOUND_W'(FLOAT_LO)));

  // R2
  pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == 2'd2) |-> (hi_bound == BOUND_W'(PULL_HI) && lo_bound == BOUND_W'(PULL_LO)));

  // R3
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(PROBE_CYC));
endmodule

bind wd_strap_probe wd_strap_probe_chk #(
  .PROBE_CYC(PROBE_CYC), .BOUND_W(BOUND_W),
  .FLOAT_LO(FLOAT_LO), .FLOAT_HI(FLOAT_HI), .PULL_LO(PULL_LO), .PULL_HI(PULL_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .chg_en(chg_en), .mode(mode),
  .lo_bound(lo_bound), .hi_bound(hi_bound), .done(done)
);

// File: tb/test_wd_strap_probe.sv
module test_wd_strap_probe;
  localparam int SETTLE = 4, PROBE = 64, BW = 32;
  localparam int unsigned F_LO = 800000, F_HI = 1600000, P_LO = 1850, P_HI = 11000;
  localparam int unsigned SCALE = 1234, FRAC = 4, OFFS = 55000;

  logic clk = 0, rst_n = 0, start = 0, pin_level = 0, cmp_force = 0;
  logic cmp_hit, chg_en, done;
  logic [1:0] mode;
  logic [BW-1:0] lo_bound, hi_bound;
  int hit_n = 1000, q = 0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) q <= chg_en ? q + 1 : 0;
  assign cmp_hit = cmp_force | (chg_en && q >= hit_n);

  wd_strap_probe #(.SETTLE_CYC(SETTLE), .PROBE_CYC(PROBE), .BOUND_W(BW),
    .FLOAT_LO(F_LO), .FLOAT_HI(F_HI), .PULL_LO(P_LO), .PULL_HI(P_HI),
    .CAP_SCALE(SCALE), .CAP_FRAC(FRAC), .CAP_OFFSET(OFFS)) i_wd_strap_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .pin_hi(pin_level), .cmp_hit(cmp_hit),
    .chg_en(chg_en), .mode(mode), .lo_bound(lo_bound), .hi_bound(hi_bound), .done(done));

  function automatic longint cap_hi(input int n);
    return ((longint'(n) * SCALE) >> FRAC) + OFFS;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_probe(input logic p0, input logic p1, input int hn,
                           output int dc, output int cc);
    pin_level = p0; hit_n = hn;
    start = 1; @(negedge clk); start = 0;
    dc = 0; cc = 0;
    while (!done && dc < 1000) begin
      @(negedge clk); dc++;
      if (chg_en) begin cc++; pin_level = p1; end
    end
  endtask

  task automatic t_reset();
    chk(done == 0 && chg_en == 0, "R1 flags", {done, chg_en}, 0);
    chk(mode == 0 && lo_bound == 0 && hi_bound == 0, "R1 result", hi_bound, 0);
  endtask

  task automatic t_idle_ignore();
    cmp_force = 1; pin_level = 1;
    repeat (5) @(negedge clk);
    chk(!done && !chg_en && mode == 0, "R8 idle cmp ignored", mode, 0);
    cmp_force = 0; pin_level = 0;
  endtask

  task automatic t_pull();
    int dc, cc;
    run_probe(1, 1, 1000, dc, cc);
    chk(dc == SETTLE, "R2 pull latency", dc, SETTLE);
    chk(cc == 0, "R2 no charge", cc, 0);
    chk(mode == 2, "R2 pull mode", mode, 2);
    chk(hi_bound == P_HI && lo_bound == P_LO, "R2 pull bounds", hi_bound, P_HI);
  endtask

  task automatic t_cap(input int n, input logic p1);
    int dc, cc;
    run_probe(0, p1, n, dc, cc);
    chk(dc == SETTLE + 1 + n, "R4 cap latency", dc, SETTLE + 1 + n);
    chk(cc == n + 1, "R3 charge length", cc, n + 1);
    chk(mode == 3, "R4 cap mode", mode, 3);
    chk(hi_bound == cap_hi(n), "R4 cap upper", hi_bound, cap_hi(n));
    chk(lo_bound == (cap_hi(n) >> 1), "R5 cap lower", lo_bound, cap_hi(n) >> 1);
    if (p1) chk(mode == 3, "R8 pin high while charging ignored", mode, 3);
  endtask

  task automatic t_float(input int n);
    int dc, cc;
    run_probe(0, 1, n, dc, cc);
    chk(dc == SETTLE + PROBE, "R6 float latency", dc, SETTLE + PROBE);
    chk(cc == PROBE, "R3 full window", cc, PROBE);
    chk(mode == 1, "R6 float mode", mode, 1);
    chk(hi_bound == F_HI && lo_bound == F_LO, "R6 float bounds", hi_bound, F_HI);
  endtask

  task automatic t_hold();
    logic [BW-1:0] h;
    h = hi_bound;
    cmp_force = 1; pin_level = ~pin_level;
    repeat (6) @(negedge clk);
    chk(done && mode == 3 && hi_bound == h, "R7 hold while done", hi_bound, h);
    chk(!chg_en, "R8 no charge while done", chg_en, 0);
    cmp_force = 0;
    start = 1; @(negedge clk); start = 0;
    chk(!done && mode == 0 && hi_bound == 0, "R7 start clears", mode, 0);
  endtask

  task automatic t_restart();
    int dc, cc;
    pin_level = 0; hit_n = 1000;
    start = 1; @(negedge clk); start = 0;
    cc = 0;
    while (cc < 10) begin @(negedge clk); if (chg_en) cc++; end
    pin_level = 1;
    start = 1; @(negedge clk); start = 0;
    chk(!done && !chg_en, "R9 restart drops charge", chg_en, 0);
    dc = 0;
    while (!done && dc < 1000) begin @(negedge clk); dc++; end
    chk(dc == SETTLE && mode == 2, "R9 restart result", dc, SETTLE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_idle_ignore();
    t_pull();
    t_cap(0, 0);
    t_cap(10, 1);
    t_cap(PROBE - 1, 0);
    t_float(PROBE);
    t_float(5000);
    t_cap(37, 0);
    t_hold();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule